// File: doc/BRIEF.md
# Serial Wire Pulse Finder

This block takes the sampled output of one detector wire, one 10-bit word at a time, and finds pulses in it. A pulse (a hit) begins where a low sample is followed by at least four high samples and ends where a high sample is followed by four low samples. For each hit the block stores the absolute time of its first high sample and its width in sample ticks. The two values go into two small separate memories that share one read address. It also reports how many hits it kept.

The block holds two consecutive words so that a pulse edge straddling a word boundary is still seen. Within a word, candidate pattern starts are examined in three groups, one group per clock cycle. The search alternates between looking for a rising pattern and a falling pattern. A start pulse arms a scan of a given number of words. A stop input cuts it short. A done flag rises when the scan is over and any unterminated hit has been closed.

Top module: `wire_hit_scanner`

## Requirements
- R1: Within a word, bit 9 is time 0 and bit 0 is time 9, and word k covers times 10k to 10k+9. A leading edge is a 0 followed by four 1s. Its stored time is the time of the first of those 1s, so word 0 `0011110000` stores 2.
- R2: In word 0 only, four 1s at times 0 to 3 count as a leading edge at time 0, with no preceding 0 needed.
- R3: Once a leading edge is stored, the block looks for a 1 followed by four 0s. The width written is the time of the first of those 0s minus the stored leading time, capped at 255. Entry i of both memories appears on the read port when `rd_addr_i` = i, with no clock delay.
- R4: A pattern that starts in one word and ends in the next is detected and gets the correct absolute time.
- R5: Each word takes three consecutive cycles of examination. Starts at times 0–3 are examined first, then 4–7, then 8–9, with at most one edge accepted per group. The next word may be presented no earlier than the third of those cycles. On the last word, starts whose pattern would run past time 9 are not examined.
- R6: At most four hits are stored. Once four are stored, further pulses leave the memories and the count unchanged.
- R7: A leading edge whose absolute time exceeds 254 is not stored and does not start a width search.
- R8: If the scan ends while a falling pattern is still being sought, the open hit's width entry is written as 255 and the hit is counted.
- R9: When `stop_i` is high during a scan, the scan ends at once. Any edge found in that same cycle is discarded, and the R8 closing applies. Words beyond `words_to_scan_i` are ignored. `done_o` rises after the scan ends and stays high until the next start. With a word count of 0, the block finishes with no hits.
- R10: `hit_count_o[2:0]` is the number of stored hits and `hit_count_o[3]` mirrors `wire_off_i`.
- R11: After reset, `done_o` is 0 and the count is 0. A start pulse clears the count, the search mode and the word position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new scan and clears scan state |
| word_vld_i | input | 1 | `word_i` holds the next sample word |
| word_i | input | 10 | Sample word, bit 9 earliest |
| words_to_scan_i | input | 6 | Number of words in this scan, up to 33 |
| stop_i | input | 1 | Ends the scan immediately |
| wire_off_i | input | 1 | Wire-off flag, reported in the count's top bit |
| rd_addr_i | input | 2 | Hit entry to read |
| le_rdata_o | output | 8 | Leading-edge time of the selected entry |
| width_rdata_o | output | 8 | Width of the selected entry |
| hit_count_o | output | 4 | {wire-off, stored hit count} |
| done_o | output | 1 | Scan finished |

## Verification
A stop request and a falling-edge detection can fall in the same cycle. The bench presents a word whose pulse ends in the second group and raises `stop_i` exactly in the cycle that group is examined. It judges the outcome through the read port: the leading time must be kept, and the width must read 255 rather than the true width. A second case stops in an idle cycle after the rising edge, so that the closing path can be compared with the coincident one.

// File: rtl/hit_scan_pkg.sv
package hit_scan_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT, ST_A, ST_B, ST_C, ST_FIN, ST_DONE
  } scan_st_e;

  typedef enum logic [1:0] {GRP_A, GRP_B, GRP_C} grp_e;
endpackage

// File: rtl/hit_group_match.sv
module hit_group_match
  import hit_scan_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int RUN_LEN = 4,
  parameter int GRP_W   = 4,
  parameter int REL_W   = 4
) (
  input  logic [WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0] nxt_i,
  input  grp_e              grp_i,
  input  logic              trail_mode_i,
  input  logic              first_word_i,
  input  logic              tail_i,
  output logic              hit_o,
  output logic [REL_W-1:0]  rel_o
);
  localparam int SW = WORD_W + RUN_LEN;

  logic [SW-1:0]     s;
  logic [WORD_W-1:0] rise_m, fall_m, fit, in_grp, pick;
  logic              special;

  // s[t] is the sample at local time t; the next word supplies the tail
  for (genvar t = 0; t < WORD_W; t++) begin : g_cur
    assign s[t] = cur_i[WORD_W-1-t];
  end
  for (genvar k = 0; k < RUN_LEN; k++) begin : g_nxt
    assign s[WORD_W+k] = nxt_i[WORD_W-1-k];
  end

  for (genvar t = 0; t < WORD_W; t++) begin : g_start
    localparam bit FITS = (t + RUN_LEN < WORD_W);
    assign rise_m[t] = ~s[t] & (&s[t+1 +: RUN_LEN]);
    assign fall_m[t] = s[t] & ~(|s[t+1 +: RUN_LEN]);
    assign fit[t]    = FITS | ~tail_i;
    assign in_grp[t] = (grp_i == GRP_A) ? (t < GRP_W) :
                       (grp_i == GRP_B) ? (t >= GRP_W && t < 2*GRP_W) :
                                          (t >= 2*GRP_W);
  end

  assign pick    = (trail_mode_i ? fall_m : rise_m) & fit & in_grp;
  assign special = (grp_i == GRP_A) & first_word_i & ~trail_mode_i & (&s[RUN_LEN-1:0]);

  always_comb begin
    hit_o = special | (|pick);
    rel_o = '0;
    if (!special) begin
      for (int i = WORD_W-1; i >= 0; i--) begin
        if (pick[i]) rel_o = REL_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/hit_store.sv
module hit_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_we_i,
  input  logic              wd_we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] le_wdata_i,
  input  logic [DATA_W-1:0] wd_wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] le_rdata_o,
  output logic [DATA_W-1:0] wd_rdata_o
);
  logic [DATA_W-1:0] le_mem [DEPTH];
  logic [DATA_W-1:0] wd_mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        le_mem[i] <= '0;
        wd_mem[i] <= '0;
      end
    end else begin
      if (le_we_i) le_mem[waddr_i] <= le_wdata_i;
      if (wd_we_i) wd_mem[waddr_i] <= wd_wdata_i;
    end
  end

  assign le_rdata_o = le_mem[raddr_i];
  assign wd_rdata_o = wd_mem[raddr_i];

  // R3
  excl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(le_we_i && wd_we_i));
endmodule

// File: rtl/wire_hit_scanner.sv
module wire_hit_scanner
  import hit_scan_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int RUN_LEN   = 4,
  parameter int GRP_W     = 4,
  parameter int MAX_HITS  = 4,
  parameter int TIME_W    = 8,
  parameter int MAX_WORDS = 33,
  parameter int MAX_LE    = 254,
  localparam int ADDR_W   = $clog2(MAX_HITS),
  localparam int CNT_W    = $clog2(MAX_HITS + 1),
  localparam int NW_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [NW_W-1:0]   words_to_scan_i,
  input  logic              stop_i,
  input  logic              wire_off_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [TIME_W-1:0] le_rdata_o,
  output logic [TIME_W-1:0] width_rdata_o,
  output logic [CNT_W:0]    hit_count_o,
  output logic              done_o
);
  localparam int ABS_W = $clog2((MAX_WORDS + 1) * WORD_W + 1);
  localparam int REL_W = $clog2(WORD_W + 2);

  scan_st_e          state_q, state_d;
  logic [WORD_W-1:0] cur_q, nxt_q;
  logic              cur_full_q, nxt_full_q, trail_q;
  logic [NW_W-1:0]   loaded_q, cur_idx_q;
  logic [ABS_W-1:0]  le_save_q;
  logic [CNT_W-1:0]  wr_addr_q;

  grp_e              grp;
  logic              scanning, accept, tail_go, shift;
  logic              hit;
  logic [REL_W-1:0]  rel;
  logic [ABS_W-1:0]  base_t, abs_t, width_raw;
  logic              le_ok, te_ok, fin_fill, wd_we;
  logic [TIME_W-1:0] wd_data;

  always_comb begin
    unique case (state_q)
      ST_B:    grp = GRP_B;
      ST_C:    grp = GRP_C;
      default: grp = GRP_A;
    endcase
  end

  assign scanning = (state_q == ST_A) || (state_q == ST_B) || (state_q == ST_C);
  assign accept   = word_vld_i && !stop_i && (loaded_q < words_to_scan_i) &&
                    ((state_q == ST_WAIT) || (state_q == ST_C));
  assign tail_go  = (state_q == ST_WAIT) && !stop_i && nxt_full_q &&
                    (loaded_q == words_to_scan_i);
  assign shift    = accept || tail_go;

  hit_group_match #(
    .WORD_W(WORD_W), .RUN_LEN(RUN_LEN), .GRP_W(GRP_W), .REL_W(REL_W)
  ) u_match (
    .cur_i        (cur_q),
    .nxt_i        (nxt_q),
    .grp_i        (grp),
    .trail_mode_i (trail_q),
    .first_word_i (cur_idx_q == '0),
    .tail_i       (!nxt_full_q),
    .hit_o        (hit),
    .rel_o        (rel)
  );

  assign base_t    = ABS_W'(cur_idx_q) * ABS_W'(WORD_W);
  assign abs_t     = base_t + ABS_W'(rel);
  assign le_ok     = scanning && !stop_i && hit && !trail_q &&
                     (abs_t <= ABS_W'(MAX_LE)) && (wr_addr_q < CNT_W'(MAX_HITS));
  assign te_ok     = scanning && !stop_i && hit && trail_q;
  assign fin_fill  = (state_q == ST_FIN) && trail_q;
  assign width_raw = abs_t - le_save_q;
  assign wd_we     = te_ok || fin_fill;
  assign wd_data   = (te_ok && width_raw <= ABS_W'((1 << TIME_W) - 1)) ?
                     width_raw[TIME_W-1:0] : '1;

  always_comb begin
    state_d = state_q;
    if (start_i) state_d = ST_WAIT;
    else begin
      unique case (state_q)
        ST_WAIT: begin
          if (stop_i)                        state_d = ST_FIN;
          else if (accept && nxt_full_q)     state_d = ST_A;
          else if (tail_go)                  state_d = ST_A;
          else if (!nxt_full_q && loaded_q == words_to_scan_i) state_d = ST_FIN;
        end
        ST_A:    state_d = stop_i ? ST_FIN : ST_B;
        ST_B:    state_d = stop_i ? ST_FIN : ST_C;
        ST_C:    state_d = stop_i ? ST_FIN : (accept ? ST_A : ST_WAIT);
        ST_FIN:  state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      cur_q      <= '0;
      nxt_q      <= '0;
      cur_full_q <= 1'b0;
      nxt_full_q <= 1'b0;
      loaded_q   <= '0;
      cur_idx_q  <= '0;
      trail_q    <= 1'b0;
      le_save_q  <= '0;
      wr_addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_i) begin
        cur_full_q <= 1'b0;
        nxt_full_q <= 1'b0;
        loaded_q   <= '0;
        cur_idx_q  <= '0;
        trail_q    <= 1'b0;
        le_save_q  <= '0;
        wr_addr_q  <= '0;
      end else begin
        if (shift) begin
          cur_q      <= nxt_q;
          cur_full_q <= nxt_full_q;
          cur_idx_q  <= cur_full_q ? cur_idx_q + 1'b1 : '0;
          if (accept) begin
            nxt_q      <= word_i;
            nxt_full_q <= 1'b1;
            loaded_q   <= loaded_q + 1'b1;
          end else begin
            nxt_full_q <= 1'b0;
          end
        end
        if (le_ok) begin
          trail_q   <= 1'b1;
          le_save_q <= abs_t;
        end else if (wd_we) begin
          trail_q   <= 1'b0;
          wr_addr_q <= wr_addr_q + 1'b1;
        end
      end
    end
  end

  hit_store #(.DEPTH(MAX_HITS), .DATA_W(TIME_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .le_we_i    (le_ok),
    .wd_we_i    (wd_we),
    .waddr_i    (wr_addr_q[ADDR_W-1:0]),
    .le_wdata_i (abs_t[TIME_W-1:0]),
    .wd_wdata_i (wd_data),
    .raddr_i    (rd_addr_i),
    .le_rdata_o (le_rdata_o),
    .wd_rdata_o (width_rdata_o)
  );

  assign hit_count_o = {wire_off_i, wr_addr_q};
  assign done_o      = (state_q == ST_DONE);

  // R6
  hit_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_q <= CNT_W'(MAX_HITS));

  // R7
  le_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trail_q) |-> le_save_q <= ABS_W'(MAX_LE));

  // R5
  grp_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_A && !start_i) |=> (state_q == ST_B || state_q == ST_FIN));

  // R5
  word_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_A || state_q == ST_B) |-> !word_vld_i);

  // R8
  done_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !trail_q);
endmodule

// File: tb/tb_wire_hit_scanner.sv
module tb_wire_hit_scanner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, vld = 1'b0, stop = 1'b0, wire_off = 1'b0;
  logic [9:0] word = '0;
  logic [5:0] nscan = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] le_rd, wd_rd;
  logic [3:0] hcnt;
  logic       done;

  always #10 clk = ~clk;

  wire_hit_scanner dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_vld_i(vld), .word_i(word),
    .words_to_scan_i(nscan), .stop_i(stop), .wire_off_i(wire_off), .rd_addr_i(rd_addr),
    .le_rdata_o(le_rd), .width_rdata_o(wd_rd), .hit_count_o(hcnt), .done_o(done)
  );

  typedef struct packed {
    logic [5:0] nsend, nscan;
    logic [9:0] w0, w1;
    logic [3:0] cnt;
    logic [7:0] le0, wd0, le1, wd1;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'd1, 6'd1, 10'b0011110000, 10'b0,          4'd1, 8'd2, 8'd4,   8'd0, 8'd0},
    '{6'd2, 6'd2, 10'b0000000011, 10'b1100000000, 4'd1, 8'd8, 8'd4,   8'd0, 8'd0},
    '{6'd1, 6'd1, 10'b1111100000, 10'b0,          4'd1, 8'd0, 8'd5,   8'd0, 8'd0},
    '{6'd2, 6'd2, 10'b0111100001, 10'b1110000000, 4'd2, 8'd1, 8'd4,   8'd9, 8'd4},
    '{6'd1, 6'd1, 10'b0000011111, 10'b0,          4'd1, 8'd5, 8'd255, 8'd0, 8'd0},
    '{6'd1, 6'd1, 10'b0011100000, 10'b0,          4'd0, 8'd0, 8'd0,   8'd0, 8'd0},
    '{6'd2, 6'd1, 10'b0000000011, 10'b1100000000, 4'd0, 8'd0, 8'd0,   8'd0, 8'd0}
  };

  int n_chk = 0, n_fail = 0;
  logic [9:0] wbuf [40];

  function automatic string vec_req(int v);
    case (v)
      0: return "R1 R3 R5";
      1: return "R4";
      2: return "R2";
      3: return "R4 R5";
      4: return "R8";
      5: return "R1";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_run(input int n);
    @(negedge clk); nscan = 6'(n); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_word(input logic [9:0] w);
    @(negedge clk); vld = 1'b1; word = w;
    @(negedge clk); vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    chk({req, " done"}, int'(done), 1);
  endtask

  task automatic check_entry(input string req, input int idx, input int le, input int wd);
    rd_addr = 2'(idx);
    #1;
    chk({req, " le"}, int'(le_rd), le);
    chk({req, " width"}, int'(wd_rd), wd);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset count", int'(hcnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      start_run(int'(VECS[v].nscan));
      for (int i = 0; i < int'(VECS[v].nsend); i++)
        send_word(i == 0 ? VECS[v].w0 : VECS[v].w1);
      wait_done(vec_req(v));
      chk({vec_req(v), " count"}, int'(hcnt), int'(VECS[v].cnt));
      if (VECS[v].cnt >= 1) check_entry(vec_req(v), 0, int'(VECS[v].le0), int'(VECS[v].wd0));
      if (VECS[v].cnt >= 2) check_entry(vec_req(v), 1, int'(VECS[v].le1), int'(VECS[v].wd1));
    end

    // R10 wire-off bit
    wire_off = 1'b1; #1;
    chk("R10 wire_off bit", int'(hcnt[3]), 1);
    wire_off = 1'b0; #1;
    chk("R10 count bits", int'(hcnt), 0);

    // R6 five pulses, four kept
    start_run(5);
    for (int i = 0; i < 5; i++) send_word(10'b0111100000);
    wait_done("R6");
    chk("R6 count", int'(hcnt), 4);
    check_entry("R6 first", 0, 1, 4);
    check_entry("R6 fourth", 3, 31, 4);

    // R7 leading edge at 254 kept
    start_run(27);
    for (int i = 0; i < 27; i++) wbuf[i] = '0;
    wbuf[25] = 10'b0000111100;
    for (int i = 0; i < 27; i++) send_word(wbuf[i]);
    wait_done("R7 254");
    chk("R7 254 count", int'(hcnt), 1);
    check_entry("R7 254", 0, 254, 4);

    // R7 leading edge at 255 dropped
    start_run(26);
    for (int i = 0; i < 26; i++) send_word(i == 25 ? 10'b0000011110 : 10'b0);
    wait_done("R7 255");
    chk("R7 255 count", int'(hcnt), 0);

    // R9 stop in an idle cycle while a hit is open
    start_run(3);
    send_word(10'b0000011111);
    send_word(10'b1111111111);
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    wait_done("R9 idle stop");
    chk("R9 idle stop count", int'(hcnt), 1);
    check_entry("R9 idle stop", 0, 5, 255);

    // R9 stop in the same cycle as a falling-edge detection
    start_run(2);
    send_word(10'b0011110000);
    @(negedge clk); vld = 1'b1; word = 10'b0;
    @(negedge clk); vld = 1'b0;
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    wait_done("R9 coincident stop");
    chk("R9 coincident count", int'(hcnt), 1);
    check_entry("R9 coincident", 0, 2, 255);

    // R9 zero words
    start_run(0);
    wait_done("R9 zero words");
    chk("R9 zero words count", int'(hcnt), 0);

    // R11 restart clears the count
    start_run(1);
    send_word(10'b0111100000);
    wait_done("R11 prep");
    chk("R11 prep count", int'(hcnt), 1);
    start_run(1);
    chk("R11 cleared count", int'(hcnt), 0);
    chk("R11 cleared done", int'(done), 0);
    send_word(10'b0);
    wait_done("R11 restart");
    chk("R11 restart count", int'(hcnt), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule